// File: doc/BRIEF.md
# Maskable Interrupt Controller With Wakeup

This block collects interrupt lines for a processor core and asks the core to take an interrupt exception. Each line has a mask bit. A line that is asserted and enabled by its mask sets a status bit, and that bit stays set. The two lowest lines are the exception: they ignore the mask and always set their status bits. Software reads and writes three registers through a small special-register port: the mask, a priority word, and the status. The priority word is storage only. It takes no part in raising requests.

The exception request is a registered output. It rises when three conditions hold together: at least one status bit is set, the core's interrupt-enable flag is high, and no other exception is already pending. It stays high while those conditions last.

Any asserted line also wakes the core, whatever the mask says. In the following cycle, the block raises two one-cycle clear strobes: one for the doze-mode enable and one for the sleep-mode enable.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, the mask, priority and status registers all read as zero, and exc_req, doze_clr and sleep_clr are low.
- R2: When line i (i of 2 or more) is high at a clock edge and mask bit i is 1, status bit i reads 1 after that edge.
- R3: When line i (i of 2 or more) is high and mask bit i is 0, status bit i is not changed.
- R4: Lines 0 and 1 set status bits 0 and 1 when they are high, whatever the mask holds.
- R5: Status bits stay set until software writes the status register (reg_sel 2). Such a write loads the written value. If a line assertion and a write hit the same bit in the same cycle, the bit ends up set.
- R6: If status is nonzero, core_ie is 1 and exc_pending is 0 at an edge, exc_req is high after that edge. It stays high while these conditions hold and falls one edge after status becomes zero.
- R7: exc_req is low after any edge at which core_ie is 0.
- R8: exc_req is low after any edge at which exc_pending is 1.
- R9: doze_clr and sleep_clr are high for exactly the cycle after an edge at which any line is high, masked or not. Otherwise they are low.
- R10: The priority register (reg_sel 1) reads back what was written to it. Its value has no effect on exc_req.
- R11: reg_sel 3 reads zero, and writes to it change no register.
- R12: The mask register (reg_sel 0) reads back the value last written to it. Register reads are combinational from reg_sel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_lines | input | NUM_LINES | Interrupt input lines, active high |
| reg_sel | input | 2 | Register select: 0 mask, 1 priority, 2 status, 3 unused |
| reg_we | input | 1 | Write strobe for the selected register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data of the selected register, combinational |
| core_ie | input | 1 | Interrupt-enable flag of the core |
| exc_pending | input | 1 | Another exception is already pending |
| exc_req | output | 1 | Interrupt exception request, registered |
| doze_clr | output | 1 | One-cycle strobe that clears the doze-mode enable |
| sleep_clr | output | 1 | One-cycle strobe that clears the sleep-mode enable |

## Verification
The bench builds the block with its defaults: 32 lines, 32-bit data and two mask-bypass lines. With these values the top status bit 31 can be written from software, a masked-out line such as 8 can be compared with enabled lines 4 and 5, and the bypass pair can be checked against a mask that is zero in its low bits. Because the data width equals the line count, every write-data bit lands in a real register bit. Write-versus-assertion collisions and the gating by enable and pending are then visible directly at reg_rdata and exc_req.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

   localparam int unsigned SEL_W = 2;

   typedef enum logic [SEL_W-1:0] {
      SEL_MASK = 2'd0,
      SEL_PRIO = 2'd1,
      SEL_STAT = 2'd2,
      SEL_NONE = 2'd3
   } irq_sel_e;

endpackage

// File: rtl/irq_ctrl_cfg_regs.sv
module irq_ctrl_cfg_regs #(
   parameter int unsigned NUM_LINES = 32,
   parameter int unsigned DATA_W    = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_mask,
   input  logic                 wr_prio,
   input  logic [DATA_W-1:0]    wdata,
   output logic [NUM_LINES-1:0] mask_q,
   output logic [DATA_W-1:0]    prio_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
      end else if (wr_mask) begin
         mask_q <= wdata[NUM_LINES-1:0];
      end
   end

   // priority word: plain storage, read back through the port only
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prio_q <= '0;
      end else if (wr_prio) begin
         prio_q <= wdata;
      end
   end

endmodule

// File: rtl/irq_ctrl_status.sv
module irq_ctrl_status #(
   parameter int unsigned NUM_LINES  = 32,
   parameter int unsigned NUM_BYPASS = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_lines,
   input  logic [NUM_LINES-1:0] mask_q,
   input  logic                 sw_wr,
   input  logic [NUM_LINES-1:0] sw_data,
   output logic [NUM_LINES-1:0] status_q
);

   logic [NUM_LINES-1:0] accept;

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_bit
      if (i < NUM_BYPASS) begin : g_bypass
         assign accept[i] = irq_lines[i];
      end else begin : g_masked
         assign accept[i] = irq_lines[i] & mask_q[i];
      end

      // an assertion beats a software write landing on the same bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            status_q[i] <= 1'b0;
         end else if (accept[i]) begin
            status_q[i] <= 1'b1;
         end else if (sw_wr) begin
            status_q[i] <= sw_data[i];
         end
      end
   end

endmodule

// File: rtl/irq_ctrl_req.sv
module irq_ctrl_req #(
   parameter int unsigned NUM_LINES = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] status_q,
   input  logic [NUM_LINES-1:0] irq_lines,
   input  logic                 core_ie,
   input  logic                 exc_pending,
   output logic                 exc_req,
   output logic                 doze_clr,
   output logic                 sleep_clr
);

   logic req_d;
   logic wake_d;

   assign req_d  = core_ie && !exc_pending && (|status_q);
   assign wake_d = |irq_lines;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exc_req   <= 1'b0;
         doze_clr  <= 1'b0;
         sleep_clr <= 1'b0;
      end else begin
         exc_req   <= req_d;
         doze_clr  <= wake_d;
         sleep_clr <= wake_d;
      end
   end

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
   parameter int unsigned NUM_LINES  = 32,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned NUM_BYPASS = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_LINES-1:0]  irq_lines,
   input  logic [1:0]            reg_sel,
   input  logic                  reg_we,
   input  logic [DATA_W-1:0]     reg_wdata,
   output logic [DATA_W-1:0]     reg_rdata,
   input  logic                  core_ie,
   input  logic                  exc_pending,
   output logic                  exc_req,
   output logic                  doze_clr,
   output logic                  sleep_clr
);
   import irq_ctrl_pkg::*;

   if (NUM_LINES < 1) begin : g_bad_lines
      $error("irq_ctrl: NUM_LINES must be at least 1");
   end
   if (DATA_W < NUM_LINES) begin : g_bad_width
      $error("irq_ctrl: DATA_W must cover NUM_LINES");
   end
   if (NUM_BYPASS > NUM_LINES) begin : g_bad_bypass
      $error("irq_ctrl: NUM_BYPASS exceeds NUM_LINES");
   end

   irq_sel_e             sel;
   logic                 wr_mask;
   logic                 wr_prio;
   logic                 wr_stat;
   logic [NUM_LINES-1:0] mask_q;
   logic [DATA_W-1:0]    prio_q;
   logic [NUM_LINES-1:0] status_q;

   assign sel     = irq_sel_e'(reg_sel);
   assign wr_mask = reg_we && (sel == SEL_MASK);
   assign wr_prio = reg_we && (sel == SEL_PRIO);
   assign wr_stat = reg_we && (sel == SEL_STAT);

   irq_ctrl_cfg_regs #(
      .NUM_LINES (NUM_LINES),
      .DATA_W    (DATA_W)
   ) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_mask (wr_mask),
      .wr_prio (wr_prio),
      .wdata   (reg_wdata),
      .mask_q  (mask_q),
      .prio_q  (prio_q)
   );

   irq_ctrl_status #(
      .NUM_LINES  (NUM_LINES),
      .NUM_BYPASS (NUM_BYPASS)
   ) u_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .irq_lines (irq_lines),
      .mask_q    (mask_q),
      .sw_wr     (wr_stat),
      .sw_data   (reg_wdata[NUM_LINES-1:0]),
      .status_q  (status_q)
   );

   irq_ctrl_req #(
      .NUM_LINES (NUM_LINES)
   ) u_req (
      .clk         (clk),
      .rst_n       (rst_n),
      .status_q    (status_q),
      .irq_lines   (irq_lines),
      .core_ie     (core_ie),
      .exc_pending (exc_pending),
      .exc_req     (exc_req),
      .doze_clr    (doze_clr),
      .sleep_clr   (sleep_clr)
   );

   always_comb begin
      case (sel)
         SEL_MASK: reg_rdata = DATA_W'(mask_q);
         SEL_PRIO: reg_rdata = prio_q;
         SEL_STAT: reg_rdata = DATA_W'(status_q);
         default:  reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
   parameter int unsigned NUM_LINES  = 32,
   parameter int unsigned NUM_BYPASS = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_LINES-1:0] irq_lines,
   input logic [1:0]           reg_sel,
   input logic                 reg_we,
   input logic                 core_ie,
   input logic                 exc_pending,
   input logic                 exc_req,
   input logic                 doze_clr,
   input logic                 sleep_clr,
   input logic [NUM_LINES-1:0] mask_q,
   input logic [NUM_LINES-1:0] status_q
);

   logic stat_wr;
   assign stat_wr = reg_we && (reg_sel == 2'd2);

   AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_wr |=> ((status_q & $past(status_q)) == $past(status_q))); // R5

   for (genvar b = 0; b < NUM_BYPASS; b++) begin : g_byp_chk
      AST_BYPASS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
         irq_lines[b] |=> status_q[b]); // R4
   end

   for (genvar m = NUM_BYPASS; m < NUM_LINES; m++) begin : g_mask_chk
      AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         (!mask_q[m] && !status_q[m] && !stat_wr) |=> !status_q[m]); // R3
      AST_ENABLED_SETS: assert property (@(posedge clk) disable iff (!rst_n)
         (mask_q[m] && irq_lines[m]) |=> status_q[m]); // R2
   end

   AST_REQ_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
      (core_ie && !exc_pending && (status_q != '0)) |=> exc_req); // R6

   AST_REQ_NO_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q == '0) |=> !exc_req); // R6

   AST_REQ_IE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !core_ie |=> !exc_req); // R7

   AST_REQ_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      exc_pending |=> !exc_req); // R8

   AST_WAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq_lines) |=> (doze_clr && sleep_clr)); // R9

   AST_WAKE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !(|irq_lines) |=> (!doze_clr && !sleep_clr)); // R9

endmodule

bind irq_ctrl irq_ctrl_chk #(
   .NUM_LINES  (NUM_LINES),
   .NUM_BYPASS (NUM_BYPASS)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .irq_lines   (irq_lines),
   .reg_sel     (reg_sel),
   .reg_we      (reg_we),
   .core_ie     (core_ie),
   .exc_pending (exc_pending),
   .exc_req     (exc_req),
   .doze_clr    (doze_clr),
   .sleep_clr   (sleep_clr),
   .mask_q      (mask_q),
   .status_q    (status_q)
);

// File: tb/irq_ctrl_tb_top.sv
module irq_ctrl_tb_top;
   import irq_ctrl_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int NL = 32;
   localparam int DW = 32;
   localparam int K_RD    = 0;
   localparam int K_REQ   = 1;
   localparam int K_DOZE  = 2;
   localparam int K_SLEEP = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NL-1:0] irq_lines = '0;
   logic [1:0]    reg_sel = 2'd0;
   logic          reg_we = 1'b0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic          core_ie = 1'b0;
   logic          exc_pending = 1'b0;
   logic          exc_req;
   logic          doze_clr;
   logic          sleep_clr;

   typedef struct {
      int          due;
      int          kind;
      logic [31:0] val;
      string       tag;
   } exp_t;

   exp_t sb_q[$];
   exp_t keep_q[$];
   int   cyc = 0;
   int   n_checks = 0;
   int   n_errors = 0;
   bit   done = 1'b0;

   irq_ctrl dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .irq_lines   (irq_lines),
      .reg_sel     (reg_sel),
      .reg_we      (reg_we),
      .reg_wdata   (reg_wdata),
      .reg_rdata   (reg_rdata),
      .core_ie     (core_ie),
      .exc_pending (exc_pending),
      .exc_req     (exc_req),
      .doze_clr    (doze_clr),
      .sleep_clr   (sleep_clr)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check_item(exp_t e);
      logic [31:0] act;
      case (e.kind)
         K_RD:    act = reg_rdata;
         K_REQ:   act = {31'd0, exc_req};
         K_DOZE:  act = {31'd0, doze_clr};
         default: act = {31'd0, sleep_clr};
      endcase
      n_checks++;
      if (act !== e.val) begin
         n_errors++;
         $display("FAIL %s (kind %0d, cycle %0d): actual 0x%08h expected 0x%08h",
                  e.tag, e.kind, cyc, act, e.val);
      end
   endtask

   // monitor: compares every item whose cycle has come, away from the clock edge
   always @(negedge clk) begin
      keep_q = {};
      foreach (sb_q[i]) begin
         if (sb_q[i].due == cyc) check_item(sb_q[i]);
         else keep_q.push_back(sb_q[i]);
      end
      sb_q = keep_q;
   end

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic expect_at(int dly, int kind, logic [31:0] v, string tag);
      exp_t e;
      e.due  = cyc + dly;
      e.kind = kind;
      e.val  = v;
      e.tag  = tag;
      sb_q.push_back(e);
   endtask

   task automatic exp_rd(logic [1:0] s, logic [31:0] v, string tag);
      reg_sel = s;
      reg_we  = 1'b0;
      expect_at(0, K_RD, v, tag);
      tick();
   endtask

   task automatic wr(logic [1:0] s, logic [31:0] v);
      reg_sel   = s;
      reg_we    = 1'b1;
      reg_wdata = v;
      tick();
      reg_we    = 1'b0;
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      if (!done) begin
         n_errors++;
         $display("FAIL watchdog: actual hung expected finish");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      tick();

      // R1 reset state
      expect_at(0, K_REQ, 0, "R1");
      expect_at(0, K_DOZE, 0, "R1");
      expect_at(0, K_SLEEP, 0, "R1");
      exp_rd(SEL_MASK, 32'h0, "R1");
      exp_rd(SEL_PRIO, 32'h0, "R1");
      exp_rd(SEL_STAT, 32'h0, "R1");

      // R12 mask write and readback
      wr(SEL_MASK, 32'h0000_00F0);
      exp_rd(SEL_MASK, 32'h0000_00F0, "R12");

      // R10 priority storage
      wr(SEL_PRIO, 32'hA5A5_0003);
      exp_rd(SEL_PRIO, 32'hA5A5_0003, "R10");

      // R2 enabled lines 4,5 latch; R3 line 8 masked; R9 wake strobes
      irq_lines = 32'h0000_0130;
      expect_at(1, K_DOZE, 1, "R9");
      expect_at(1, K_SLEEP, 1, "R9");
      expect_at(2, K_DOZE, 0, "R9");
      expect_at(2, K_SLEEP, 0, "R9");
      tick();
      irq_lines = '0;
      exp_rd(SEL_STAT, 32'h0000_0030, "R2 R3");
      expect_at(0, K_REQ, 0, "R7");

      // R4 bypass lines ignore a zero mask
      irq_lines = 32'h0000_0003;
      tick();
      irq_lines = '0;
      exp_rd(SEL_STAT, 32'h0000_0033, "R4");

      // R8 pending blocks the request
      exc_pending = 1'b1;
      core_ie = 1'b1;
      expect_at(1, K_REQ, 0, "R8");
      tick();
      expect_at(1, K_REQ, 0, "R8");
      tick();

      // R6 request raised and held
      exc_pending = 1'b0;
      expect_at(1, K_REQ, 1, "R6");
      expect_at(3, K_REQ, 1, "R6");
      tick(); tick(); tick();

      // R7 enable low drops it
      core_ie = 1'b0;
      expect_at(1, K_REQ, 0, "R7");
      tick(); tick();
      core_ie = 1'b1;
      expect_at(1, K_REQ, 1, "R6");
      tick();

      // R6 falls one edge after status clears; R5 software clear
      expect_at(1, K_REQ, 1, "R6");
      expect_at(2, K_REQ, 0, "R6");
      wr(SEL_STAT, 32'h0);
      tick();
      exp_rd(SEL_STAT, 32'h0, "R5");

      // R5 sticky bit
      irq_lines = 32'h0000_0010;
      tick();
      irq_lines = '0;
      tick(); tick();
      exp_rd(SEL_STAT, 32'h0000_0010, "R5");

      // R5 write of zero collides with assertion of bits 4,5
      irq_lines = 32'h0000_0030;
      wr(SEL_STAT, 32'h0);
      irq_lines = '0;
      exp_rd(SEL_STAT, 32'h0000_0030, "R5");

      // R5 software sets a bit
      wr(SEL_STAT, 32'h8000_0000);
      exp_rd(SEL_STAT, 32'h8000_0000, "R5");

      // R11 unused select
      wr(SEL_NONE, 32'hFFFF_FFFF);
      exp_rd(SEL_NONE, 32'h0, "R11");
      exp_rd(SEL_MASK, 32'h0000_00F0, "R11");
      exp_rd(SEL_PRIO, 32'hA5A5_0003, "R11");
      exp_rd(SEL_STAT, 32'h8000_0000, "R11");

      // R10 priority has no effect on request
      wr(SEL_STAT, 32'h0);
      wr(SEL_PRIO, 32'hFFFF_FFFF);
      expect_at(0, K_REQ, 0, "R10");
      expect_at(2, K_REQ, 0, "R10");
      exp_rd(SEL_PRIO, 32'hFFFF_FFFF, "R10");
      tick();

      // R9 masked line still wakes, R3 status untouched
      irq_lines = 32'h0000_0100;
      expect_at(1, K_DOZE, 1, "R9");
      expect_at(1, K_SLEEP, 1, "R9");
      expect_at(2, K_DOZE, 0, "R9");
      tick();
      irq_lines = '0;
      exp_rd(SEL_STAT, 32'h0, "R3");

      repeat (4) tick();
      if (sb_q.size() != 0) begin
         n_errors++;
         $display("FAIL scoreboard: actual %0d items left expected 0", sb_q.size());
      end
      done = 1'b1;
      summary();
      $finish;
   end

endmodule